// File: doc/BRIEF.md
# Serial Register Access Port

This block is the device side of a four-wire serial port (serial clock, data in, data out, active-low select). It runs on the chip clock and oversamples the serial pins. Every exchange starts with a one-byte command. The command picks a direction and one of eight internal registers. The addressed register is then written from DIN or read onto DOUT, MSB first, with a length that depends on the register. The configuration registers are presented as parallel outputs to the rest of the chip. A conversion result and a status byte come in on parallel inputs.

A pulse on `data_load` captures a new conversion result and drives the ready flag low. In continuous-read mode the result is shifted out after each load with no command in front of it. While in that mode the port keeps watching DIN for the byte that ends the mode. A run of 32 ones on DIN brings the whole port back to its power-on state, whatever it was doing.

Top module: `sreg_port`

## Requirements
- R1: After reset, the register outputs hold their power-on values: mode 0x000A, config 0x0710, io 0x00, offset 0x800000 and full-scale 0x5A5A5A. At the same point `rdy_n` is 1 and `dout` is 0.
- R2: While a command is awaited, a 1 sampled on DIN at the first bit position is dropped and that position is sampled again. The first 0 starts the command, and the next seven bits complete it.
- R3: The command byte holds, from MSB to LSB: bit7 = 0, bit6 = direction (1 read, 0 write), bits5:3 = address, bit2 = continuous flag, bits1:0 = 0. The address map is 0 = status/command, 1 = mode (16 bits), 2 = config (16 bits), 3 = data (24 bits), 4 = ID (8 bits), 5 = io (8 bits), 6 = offset (24 bits) and 7 = full-scale (24 bits). A write shifts that many bits in, MSB first, into the addressed register.
- R4: A read shifts the addressed register out on `dout`, MSB first, with the width from R3. `dout` changes only after a falling SCLK edge, and each bit is valid at the next rising edge.
- R5: A write to address 0, 3 or 4 is clocked in but discarded, and no register changes.
- R6: A read of address 4 returns the constant 0xA9.
- R7: A read of address 0 returns `{rdy_n, status_in[6:0]}`.
- R8: A `data_load` pulse captures `data_in` into the data register and drives `rdy_n` low. A complete read of the data register drives `rdy_n` high again.
- R9: Command 0x5C enters continuous-read mode. After that, every `data_load` causes the next 24 SCLK cycles to shift the captured result out on `dout`, with no command needed. The ready flag rises after the 24th bit.
- R10: In continuous-read mode, the byte 0x58 received while `rdy_n` is low ends the mode. Later results are no longer shifted out unless a command asks for them.
- R11: 32 consecutive rising SCLK edges with DIN high, with select active, return all registers and the port to their power-on state. The port then waits for a command.
- R12: Raising `cs_n` during a transfer abandons it with no register write. The next command byte is taken from a fresh byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial data into the port |
| dout | output | 1 | Serial data out of the port |
| data_load | input | 1 | One-cycle pulse: new conversion result present |
| data_in | input | DATA_W | Conversion result |
| status_in | input | 8 | Status bits; bit 7 is replaced by the ready flag |
| rdy_n | output | 1 | Ready flag, low while an unread result is held |
| mode_q | output | 16 | Mode register |
| conf_q | output | 16 | Configuration register |
| io_q | output | 8 | IO register |
| ofs_q | output | DATA_W | Offset register |
| fs_q | output | DATA_W | Full-scale register |

## Verification
The assertions check these rules on every cycle:
- A high select always leaves the command decoder idle at bit zero.
- `dout` moves only after a falling serial edge.
- A resync pulse always follows a rising edge sampled with DIN high.
- The ready flag follows loads and completed reads.
- Writes to the data address never touch the result.
- A resync restores the power-on register values.

Only the bench scenarios can show the following:
- Byte framing with a write-enable stall.
- Readback order and width for each address.
- The mode-entry and mode-exit bytes.
- A 32-bit run of ones ending a session.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD} st_e;

  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_MODE = 3'd1;
  localparam logic [2:0] A_CONF = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_ID   = 3'd4;
  localparam logic [2:0] A_IO   = 3'd5;
  localparam logic [2:0] A_OFS  = 3'd6;
  localparam logic [2:0] A_FS   = 3'd7;

  // bit length of a register transfer for a given address
  function automatic logic [4:0] reg_len(input logic [2:0] a, input int dw);
    case (a)
      A_MODE, A_CONF:       reg_len = 5'd16;
      A_DATA, A_OFS, A_FS:  reg_len = 5'(dw);
      default:              reg_len = 5'd8;
    endcase
  endfunction

endpackage

// File: rtl/sreg_edge.sv
module sreg_edge #(
  parameter int RUN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic rise,
  output logic fall,
  output logic resync
);
  localparam int RW = $clog2(RUN + 1);

  logic          sclk_q;
  logic [RW-1:0] run_q, run_d;
  logic          rs_q, rs_d;

  assign rise   = !cs_n && sclk && !sclk_q;
  assign fall   = !cs_n && !sclk && sclk_q;
  assign resync = rs_q;

  always_comb begin
    run_d = run_q;
    rs_d  = 1'b0;
    if (cs_n) begin
      run_d = '0;
    end else if (rise) begin
      if (!din) begin
        run_d = '0;
      end else if (run_q == RW'(RUN - 1)) begin
        run_d = '0;
        rs_d  = 1'b1;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      run_q  <= '0;
      rs_q   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      run_q  <= run_d;
      rs_q   <= rs_d;
    end
  end

  // R11
  resync_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> $past(rise && din));

endmodule

// File: rtl/sreg_file.sv
module sreg_file
  import sreg_pkg::*;
#(
  parameter int          DATA_W   = 24,
  parameter logic [7:0]  ID_VAL   = 8'hA9,
  parameter logic [15:0] MODE_RST = 16'h000A,
  parameter logic [15:0] CONF_RST = 16'h0710,
  parameter logic [7:0]  IO_RST   = 8'h00,
  parameter logic [DATA_W-1:0] OFS_RST = DATA_W'(24'h800000 >> (24 - DATA_W)),
  parameter logic [DATA_W-1:0] FS_RST  = DATA_W'(24'h5A5A5A >> (24 - DATA_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [2:0]        waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [2:0]        raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              data_load,
  input  logic [DATA_W-1:0] data_in,
  input  logic              rd_done,
  input  logic [7:0]        status_in,
  output logic [15:0]       mode_q,
  output logic [15:0]       conf_q,
  output logic [7:0]        io_q,
  output logic [DATA_W-1:0] ofs_q,
  output logic [DATA_W-1:0] fs_q,
  output logic              rdy_n
);
  logic [15:0]       mode_d, conf_d;
  logic [7:0]        io_d;
  logic [DATA_W-1:0] ofs_d, fs_d, data_q, data_d;
  logic              rdy_d;

  always_comb begin
    mode_d = mode_q;
    conf_d = conf_q;
    io_d   = io_q;
    ofs_d  = ofs_q;
    fs_d   = fs_q;
    data_d = data_q;
    rdy_d  = rdy_n;
    if (clr) begin
      mode_d = MODE_RST;
      conf_d = CONF_RST;
      io_d   = IO_RST;
      ofs_d  = OFS_RST;
      fs_d   = FS_RST;
      data_d = '0;
      rdy_d  = 1'b1;
    end else begin
      if (we) begin
        case (waddr)
          A_MODE:  mode_d = wdata[15:0];
          A_CONF:  conf_d = wdata[15:0];
          A_IO:    io_d   = wdata[7:0];
          A_OFS:   ofs_d  = wdata;
          A_FS:    fs_d   = wdata;
          default: ;
        endcase
      end
      if (data_load) begin
        data_d = data_in;
        rdy_d  = 1'b0;
      end else if (rd_done) begin
        rdy_d  = 1'b1;
      end
    end
  end

  // read value, left-justified to the shifter width
  always_comb begin
    rdata = '0;
    case (raddr)
      A_STAT:  rdata[DATA_W-1 -: 8]  = {rdy_n, status_in[6:0]};
      A_MODE:  rdata[DATA_W-1 -: 16] = mode_q;
      A_CONF:  rdata[DATA_W-1 -: 16] = conf_q;
      A_DATA:  rdata = data_q;
      A_ID:    rdata[DATA_W-1 -: 8]  = ID_VAL;
      A_IO:    rdata[DATA_W-1 -: 8]  = io_q;
      A_OFS:   rdata = ofs_q;
      default: rdata = fs_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      conf_q <= CONF_RST;
      io_q   <= IO_RST;
      ofs_q  <= OFS_RST;
      fs_q   <= FS_RST;
      data_q <= '0;
      rdy_n  <= 1'b1;
    end else begin
      mode_q <= mode_d;
      conf_q <= conf_d;
      io_q   <= io_d;
      ofs_q  <= ofs_d;
      fs_q   <= fs_d;
      data_q <= data_d;
      rdy_n  <= rdy_d;
    end
  end

  // R8
  rdy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_load && !clr) |=> !rdy_n);

  // R8
  rdy_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !data_load && !clr) |=> rdy_n);

  // R5
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == A_DATA && !data_load && !clr) |=> $stable(data_q));

  // R11
  clr_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mode_q == MODE_RST && conf_q == CONF_RST && io_q == IO_RST && rdy_n));

endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter int          DATA_W     = 24,
  parameter int          RESYNC_RUN = 32,
  parameter logic [7:0]  ID_VAL     = 8'hA9,
  parameter logic [15:0] MODE_RST   = 16'h000A,
  parameter logic [15:0] CONF_RST   = 16'h0710,
  parameter logic [7:0]  IO_RST     = 8'h00,
  parameter logic [DATA_W-1:0] OFS_RST = DATA_W'(24'h800000 >> (24 - DATA_W)),
  parameter logic [DATA_W-1:0] FS_RST  = DATA_W'(24'h5A5A5A >> (24 - DATA_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  input  logic              data_load,
  input  logic [DATA_W-1:0] data_in,
  input  logic [7:0]        status_in,
  output logic              rdy_n,
  output logic [15:0]       mode_q,
  output logic [15:0]       conf_q,
  output logic [7:0]        io_q,
  output logic [DATA_W-1:0] ofs_q,
  output logic [DATA_W-1:0] fs_q
);
  localparam logic [7:0] CMD_CR_ON  = 8'h5C;
  localparam logic [7:0] CMD_CR_OFF = 8'h58;

  logic [1:0] rs_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic rise, fall, resync;

  sreg_edge #(.RUN(RESYNC_RUN)) u_edge (
    .clk(clk), .rst_n(rst_s_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .rise(rise), .fall(fall), .resync(resync)
  );

  st_e               st_q, st_d;
  logic [4:0]        cnt_q, cnt_d, len_q, len_d, rcnt_q, rcnt_d;
  logic [5:0]        csr_q, csr_d;
  logic [2:0]        addr_q, addr_d;
  logic [DATA_W-1:0] wsr_q, wsr_d, osr_q, osr_d, rdata;
  logic              dout_q, dout_d, cread_q, cread_d;
  logic              we, rd_done;
  logic [7:0]        cbyte;

  assign cbyte = {1'b0, csr_q, din};
  assign dout  = dout_q;

  sreg_file #(
    .DATA_W(DATA_W), .ID_VAL(ID_VAL), .MODE_RST(MODE_RST), .CONF_RST(CONF_RST),
    .IO_RST(IO_RST), .OFS_RST(OFS_RST), .FS_RST(FS_RST)
  ) u_file (
    .clk(clk), .rst_n(rst_s_n), .clr(resync), .we(we), .waddr(addr_q),
    .wdata(wsr_d), .raddr(cbyte[5:3]), .rdata(rdata), .data_load(data_load),
    .data_in(data_in), .rd_done(rd_done), .status_in(status_in),
    .mode_q(mode_q), .conf_q(conf_q), .io_q(io_q), .ofs_q(ofs_q), .fs_q(fs_q),
    .rdy_n(rdy_n)
  );

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    rcnt_d  = rcnt_q;
    csr_d   = csr_q;
    addr_d  = addr_q;
    wsr_d   = wsr_q;
    osr_d   = osr_q;
    dout_d  = dout_q;
    cread_d = cread_q;
    we      = 1'b0;
    rd_done = 1'b0;
    if (resync) begin
      st_d    = ST_CMD;
      cnt_d   = '0;
      rcnt_d  = '0;
      cread_d = 1'b0;
      dout_d  = 1'b0;
    end else begin
      if (cs_n) begin
        st_d   = ST_CMD;
        cnt_d  = '0;
        rcnt_d = '0;
      end
      if (fall) begin
        if (st_q == ST_RD || (st_q == ST_CMD && cread_q && !rdy_n)) begin
          dout_d = osr_q[DATA_W-1];
          osr_d  = {osr_q[DATA_W-2:0], 1'b0};
        end else begin
          dout_d = 1'b0;
        end
      end
      if (rise) begin
        case (st_q)
          ST_CMD: begin
            if (cread_q && !rdy_n) begin
              rcnt_d = rcnt_q + 5'd1;
              if (rcnt_q == 5'(DATA_W - 1)) begin
                rd_done = 1'b1;
                rcnt_d  = '0;
              end
            end
            if (cnt_q == 5'd0) begin
              cnt_d = din ? 5'd0 : 5'd1;
            end else if (cnt_q != 5'd7) begin
              csr_d = {csr_q[4:0], din};
              cnt_d = cnt_q + 5'd1;
            end else begin
              cnt_d = '0;
              if (cread_q) begin
                if (cbyte == CMD_CR_OFF && !rdy_n) cread_d = 1'b0;
              end else if (cbyte == CMD_CR_ON) begin
                cread_d = 1'b1;
                rcnt_d  = '0;
              end else if (cbyte[6]) begin
                st_d   = ST_RD;
                osr_d  = rdata;
                addr_d = cbyte[5:3];
                len_d  = reg_len(cbyte[5:3], DATA_W);
              end else if (cbyte[5:3] != A_STAT) begin
                st_d   = ST_WR;
                addr_d = cbyte[5:3];
                len_d  = reg_len(cbyte[5:3], DATA_W);
              end
            end
          end
          ST_WR: begin
            wsr_d = {wsr_q[DATA_W-2:0], din};
            cnt_d = cnt_q + 5'd1;
            if (cnt_q == len_q - 5'd1) begin
              we    = 1'b1;
              st_d  = ST_CMD;
              cnt_d = '0;
            end
          end
          default: begin
            cnt_d = cnt_q + 5'd1;
            if (cnt_q == len_q - 5'd1) begin
              rd_done = (addr_q == A_DATA);
              st_d    = ST_CMD;
              cnt_d   = '0;
            end
          end
        endcase
      end
      if (data_load && cread_q) begin
        osr_d  = data_in;
        rcnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q    <= ST_CMD;
      cnt_q   <= '0;
      len_q   <= '0;
      rcnt_q  <= '0;
      csr_q   <= '0;
      addr_q  <= '0;
      wsr_q   <= '0;
      osr_q   <= '0;
      dout_q  <= 1'b0;
      cread_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      rcnt_q  <= rcnt_d;
      csr_q   <= csr_d;
      addr_q  <= addr_d;
      wsr_q   <= wsr_d;
      osr_q   <= osr_d;
      dout_q  <= dout_d;
      cread_q <= cread_d;
    end
  end

  // R12
  abort_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    cs_n |=> (st_q == ST_CMD && cnt_q == 5'd0));

  // R4
  dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!fall && !resync) |=> $stable(dout_q));

endmodule

// File: tb/sim_sreg_port.sv
module sim_sreg_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1;
  logic        cs_n = 1'b1;
  logic        din = 1'b0;
  logic        data_load = 1'b0;
  logic [23:0] data_in = '0;
  logic [7:0]  status_in = '0;
  logic        dout, rdy_n;
  logic [15:0] mode_q, conf_q;
  logic [7:0]  io_q;
  logic [23:0] ofs_q, fs_q;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sreg_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .dout(dout),
    .data_load(data_load), .data_in(data_in), .status_in(status_in),
    .rdy_n(rdy_n), .mode_q(mode_q), .conf_q(conf_q), .io_q(io_q),
    .ofs_q(ofs_q), .fs_q(fs_q)
  );

  typedef struct packed {
    logic [2:0]  a;
    logic [23:0] w;
    logic [23:0] e;
  } vec_t;

  // write value, then expected readback (right-justified)
  localparam vec_t VEC [7] = '{
    '{3'd1, 24'h001234, 24'h001234},   // R3 mode
    '{3'd2, 24'h00BEEF, 24'h00BEEF},   // R3 config
    '{3'd5, 24'h00003C, 24'h00003C},   // R3 io
    '{3'd6, 24'h123456, 24'h123456},   // R3 offset
    '{3'd7, 24'hABCDEF, 24'hABCDEF},   // R3 full-scale
    '{3'd4, 24'h000055, 24'h0000A9},   // R5 R6 ID
    '{3'd3, 24'h777777, 24'h000000}    // R5 data
  };

  function automatic int blen(input logic [2:0] a);
    case (a)
      3'd1, 3'd2:       blen = 16;
      3'd3, 3'd6, 3'd7: blen = 24;
      default:          blen = 8;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic o);
    sclk = 1'b0;
    din  = b;
    repeat (4) @(negedge clk);
    o = dout;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic shift(input logic [23:0] v, input int n, output logic [23:0] got);
    logic o;
    got = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bitx(v[i], o);
      got = {got[22:0], o};
    end
    din = 1'b0;
  endtask

  task automatic sel;
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel;
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_load(input logic [23:0] v);
    data_in   = v;
    data_load = 1'b1;
    @(negedge clk);
    data_load = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 mode", {8'h0, mode_q}, 24'h00000A);
    chk("R1 conf", {8'h0, conf_q}, 24'h000710);
    chk("R1 io", {16'h0, io_q}, 24'h0);
    chk("R1 ofs", ofs_q, 24'h800000);
    chk("R1 fs", fs_q, 24'h5A5A5A);
    chk("R1 rdy_n dout", {22'h0, rdy_n, dout}, 24'h2);

    // R2 leading ones are stalled on
    sel();
    shift(24'h7, 3, g);
    shift(24'h08, 8, g);
    shift(24'hC3A5, 16, g);
    desel();
    chk("R2 mode after stalled command", {8'h0, mode_q}, 24'h00C3A5);

    // R3 R4 R5 R6 table walk: write then read back
    for (int k = 0; k < 7; k++) begin
      sel();
      shift({16'h0, 2'b00, VEC[k].a, 3'b000}, 8, g);
      shift(VEC[k].w, blen(VEC[k].a), g);
      desel();
      sel();
      shift({16'h0, 2'b01, VEC[k].a, 3'b000}, 8, g);
      shift(24'h0, blen(VEC[k].a), g);
      desel();
      chk($sformatf("R4 readback addr %0d", VEC[k].a), g, VEC[k].e);
    end
    chk("R3 mode port", {8'h0, mode_q}, 24'h001234);
    chk("R3 fs port", fs_q, 24'hABCDEF);

    // R7 R8 status and data
    status_in = 8'hAB;
    pulse_load(24'h9ABCDE);
    chk("R8 rdy_n low after load", {23'h0, rdy_n}, 24'h0);
    sel();
    shift(24'h40, 8, g);
    shift(24'h0, 8, g);
    desel();
    chk("R7 status", g, 24'h00002B);
    sel();
    shift(24'h18, 8, g);
    shift(24'h111111, 24, g);
    desel();
    chk("R5 data write keeps rdy_n", {23'h0, rdy_n}, 24'h0);
    sel();
    shift(24'h58, 8, g);
    shift(24'h0, 24, g);
    desel();
    chk("R8 data read", g, 24'h9ABCDE);
    chk("R8 rdy_n high after read", {23'h0, rdy_n}, 24'h1);

    // R12 abort partial write
    sel();
    shift(24'h10, 8, g);
    shift(24'h1B, 5, g);
    desel();
    chk("R12 conf kept", {8'h0, conf_q}, 24'h00BEEF);
    sel();
    shift(24'h28, 8, g);
    shift(24'h81, 8, g);
    desel();
    chk("R12 next command framed", {16'h0, io_q}, 24'h000081);

    // R9 continuous read
    sel();
    shift(24'h5C, 8, g);
    pulse_load(24'hF0A5C3);
    chk("R9 rdy_n low", {23'h0, rdy_n}, 24'h0);
    shift(24'h0, 24, g);
    chk("R9 first result", g, 24'hF0A5C3);
    chk("R9 rdy_n high", {23'h0, rdy_n}, 24'h1);
    pulse_load(24'h0F1E2D);
    shift(24'h0, 24, g);
    chk("R9 second result", g, 24'h0F1E2D);

    // R10 exit while result pending
    pulse_load(24'h123456);
    shift(24'h58, 8, g);
    chk("R10 bits out before exit", g, 24'h000012);
    pulse_load(24'hFFFFFF);
    shift(24'h0, 8, g);
    chk("R10 no automatic output", g, 24'h0);
    shift(24'h58, 8, g);
    shift(24'h0, 24, g);
    desel();
    chk("R10 explicit read", g, 24'hFFFFFF);

    // R11 run of ones resets everything
    sel();
    shift(24'hFFFFFF, 24, g);
    shift(24'hFFFF, 16, g);
    chk("R11 mode reset", {8'h0, mode_q}, 24'h00000A);
    chk("R11 conf reset", {8'h0, conf_q}, 24'h000710);
    chk("R11 io ofs reset", {io_q, ofs_q[23:8]}, 24'h008000);
    chk("R11 fs reset", fs_q, 24'h5A5A5A);
    shift(24'h08, 8, g);
    shift(24'h0F0F, 16, g);
    desel();
    chk("R11 command after resync", {8'h0, mode_q}, 24'h000F0F);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule